// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the control side of a 16-bit, word-wide flash device. It watches an asynchronous-style bus made of chip enable, output enable, write enable and a reset/power-down pin. All of these are sampled in the block's clock domain. Command cycles are decoded and turned into automated operations. A word write can only clear bits. A block erase returns a whole block to all ones. Both operations run for a programmable busy delay, and both can be suspended and later resumed. While an erase is suspended, reads from other blocks are allowed, and so is a word write to another block.

An 8-bit status register reports progress and errors. A read returns one of three things, chosen by the last mode command: array data, the status register, or a pair of identifier words. A small internal memory stands in for the cells. It is laid out in three kinds of block: two boot blocks, six parameter blocks and fifteen main blocks. A main block is eight times the size of a small block. A strap input places the boot blocks at the top or the bottom of the address space. Writes and erases are blocked in two cases: the write-protect pin is low and the target is a boot block, or the supply-low input is asserted.

Top module: `fci_ctrl`

## Requirements
- R1: Command 20h followed by D0h starts an erase of the block that holds the second-cycle address. `ready` goes low. After the busy delay every word of that block reads FFFFh, and words of other blocks keep their values.
- R2: Command 40h or 10h followed by an address/data cycle starts a word write. The stored word becomes old AND data. A data bit of 1 where the cell holds 0 raises no error.
- R3: If an erase setup (20h) is followed by any byte other than D0h, SR.5 and SR.4 are set, the array is unchanged and reads return status.
- R4: B0h suspends the running operation. SR.7 becomes 1, and SR.2 is set for a suspended write or SR.6 for a suspended erase. D0h resumes the operation, after which reads return status and SR.7 is 0 until the operation finishes.
- R5: During an erase suspend, a word write to another block runs to completion while SR.6 stays set. A word write aimed at the suspended block sets SR.4 and leaves the array unchanged.
- R6: While an operation is suspended, FFh followed by a read returns array data from other locations.
- R7: Status layout: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 write error, bit 3 supply low, bit 2 write suspended, bit 1 protect abort, bit 0 always 0. The idle value after reset is 80h.
- R8: The status value is captured when chip enable and output enable first both go low. It does not change while they stay low. An updated value appears only after they are released and asserted again.
- R9: With `wp_n` low, a write or erase that targets a boot block is not started and SR.1 is set. Parameter and main blocks are not affected by `wp_n`. With `wp_n` high, boot blocks can be written.
- R10: With `vpp_low` high, any erase or write is not started and SR.3 is set.
- R11: Command 50h clears SR.5, SR.4, SR.3 and SR.1. These bits otherwise stay set across later successful operations.
- R12: FFh selects array reads. 90h selects identifier reads: address bit 0 = 0 returns MFG_ID (default 0042h) and bit 0 = 1 returns DEV_ID (default 00A7h). 70h selects status reads.
- R13: The block map is in units of 4 words (default geometry). With `boot_top` = 1, units 126 and 127 are boot blocks and units 120–125 are parameter blocks. With `boot_top` = 0, units 0 and 1 are boot blocks and units 2–7 are parameter blocks. A main block is 8 aligned units.
- R14: `rp_n` low abandons any running operation, clears status to 80h and selects array reads. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset, also fills the array with FFFFh |
| rp_n | input | 1 | Reset/power-down pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a command is taken when the write cycle ends |
| wp_n | input | 1 | Write protect for boot blocks, active low |
| vpp_low | input | 1 | Program supply below lockout level |
| boot_top | input | 1 | Strap: 1 = boot blocks at top of space |
| addr | input | 9 | Word address |
| wdata | input | 16 | Write data / command byte in bits 7:0 |
| rdata | output | 16 | Read data, zero when not output-enabled |
| ready | output | 1 | High when no operation is running |

## Verification
The bench targets the interplay of suspend and nesting. One case is a write into the suspended erase block: a design that allowed it would corrupt the block that is about to be erased. Another is resume ordering: a design that resumed the erase under a still-pending write would hang or erase early. It also holds output enable low across the end of an operation. A design that fed status through live would show 80h there, where the latched 00h is expected. Further cases check that error bits persist until 50h, and that the boot-block lock follows the strap at both ends of the map. A design that ANDed in the wrong direction, or that flagged raised bits, would fail the overwrite case.

// File: rtl/fci_pkg.sv
package fci_pkg;
    localparam int SUB_W     = 2;               // log2 words per small block
    localparam int UNIT_W    = 7;               // 128 small-block units
    localparam int MAIN_W    = 3;               // 8 units per main block
    localparam int AW        = UNIT_W + SUB_W;
    localparam int DW        = 16;
    localparam int PW        = SUB_W + MAIN_W;  // sweep pointer width
    localparam int NUM_UNITS = 1 << UNIT_W;
    localparam int BOOT_N    = 2;
    localparam int SMALL_N   = 8;               // boot + parameter units

    localparam logic [7:0] C_ERASE  = 8'h20;
    localparam logic [7:0] C_WRITE  = 8'h40;
    localparam logic [7:0] C_WRITE2 = 8'h10;
    localparam logic [7:0] C_CONF   = 8'hD0;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [7:0] C_ARRAY  = 8'hFF;
    localparam logic [7:0] C_STAT   = 8'h70;
    localparam logic [7:0] C_CLEAR  = 8'h50;
    localparam logic [7:0] C_IDENT  = 8'h90;

    typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_ID} rmode_e;
    typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_WRITE} pend_e;
    typedef enum logic [2:0] {RQ_NONE, RQ_ERASE, RQ_ERASE_BAD, RQ_WRITE,
                              RQ_SUSPEND, RQ_RESUME, RQ_CLEAR} rq_e;

    typedef struct packed {
        rq_e             kind;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
    } req_t;

    function automatic logic is_boot(input logic [AW-1:0] a, input logic top);
        logic [UNIT_W-1:0] u;
        u = a[AW-1:SUB_W];
        return top ? (int'(u) >= NUM_UNITS - BOOT_N) : (int'(u) < BOOT_N);
    endfunction

    function automatic logic is_main(input logic [AW-1:0] a, input logic top);
        logic [UNIT_W-1:0] u;
        u = a[AW-1:SUB_W];
        return top ? (int'(u) < NUM_UNITS - SMALL_N) : (int'(u) >= SMALL_N);
    endfunction

    function automatic logic [AW-1:0] blk_base(input logic [AW-1:0] a, input logic top);
        logic [AW-1:0] b;
        b = a;
        if (is_main(a, top)) b[PW-1:0] = '0;
        else                 b[SUB_W-1:0] = '0;
        return b;
    endfunction
endpackage

// File: rtl/fci_decode.sv
module fci_decode
    import fci_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rp_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output req_t          req,
    output rmode_e        mode
);
    logic  wr, wr_q, strobe;
    pend_e pend;
    logic [7:0] cmd;

    assign wr     = !ce_n && !we_n;
    assign strobe = wr_q && !wr;
    assign cmd    = wdata[7:0];

    always_comb begin
        req      = '{kind: RQ_NONE, addr: addr, data: wdata};
        if (strobe) begin
            unique case (pend)
                PD_ERASE: req.kind = (cmd == C_CONF) ? RQ_ERASE : RQ_ERASE_BAD;
                PD_WRITE: req.kind = RQ_WRITE;
                default: begin
                    if (cmd == C_SUSP)       req.kind = RQ_SUSPEND;
                    else if (cmd == C_CONF)  req.kind = RQ_RESUME;
                    else if (cmd == C_CLEAR) req.kind = RQ_CLEAR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rp_n) begin
            wr_q <= 1'b0;
            pend <= PD_NONE;
            mode <= RD_ARRAY;
        end else begin
            wr_q <= wr;
            if (strobe) begin
                if (pend != PD_NONE) begin
                    pend <= PD_NONE;
                    mode <= RD_STATUS;
                end else begin
                    case (cmd)
                        C_ERASE:           pend <= PD_ERASE;
                        C_WRITE, C_WRITE2: pend <= PD_WRITE;
                        C_ARRAY:           mode <= RD_ARRAY;
                        C_IDENT:           mode <= RD_ID;
                        C_STAT, C_SUSP, C_CONF: mode <= RD_STATUS;
                        default: ;
                    endcase
                end
            end
        end
    end

    assert_rp_array_R14: assert property (@(posedge clk) disable iff (rst)
        !rp_n |=> (mode == RD_ARRAY));
endmodule

// File: rtl/fci_engine.sv
module fci_engine
    import fci_pkg::*;
#(
    parameter int BUSY_CYC = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rp_n,
    input  logic          wp_n,
    input  logic          vpp_low,
    input  logic          boot_top,
    input  req_t          req,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] arr_word,
    output logic [7:0]    sr,
    output logic          ready
);
    localparam int CW    = $clog2(BUSY_CYC + 1);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    logic          e_act, e_susp, w_act, w_susp;
    logic [CW-1:0] e_cnt, w_cnt;
    logic [PW-1:0] e_ptr, e_last;
    logic [AW-1:0] e_base, w_addr;
    logic [DW-1:0] w_data;
    logic          f_er, f_wr, f_vpp, f_prot;
    logic          w_run, e_run, busy, prot_hit, idle;
    logic          mem_we;
    logic [AW-1:0] mem_wa;
    logic [DW-1:0] mem_wd;

    assign w_run    = w_act && !w_susp;
    assign e_run    = e_act && !e_susp && !w_run;
    assign busy     = w_run || (e_act && !e_susp);
    assign ready    = !busy;
    assign idle     = !w_act && !e_act;
    assign prot_hit = !wp_n && is_boot(req.addr, boot_top);
    assign sr       = {!busy, e_susp, f_er, f_wr, f_vpp, w_susp, f_prot, 1'b0};
    assign arr_word = mem[rd_addr];

    always_comb begin
        mem_we = 1'b0;
        mem_wa = w_addr;
        mem_wd = mem[w_addr] & w_data;
        if (w_run && w_cnt == '0) begin
            mem_we = 1'b1;
        end else if (e_run && e_cnt == '0) begin
            mem_we = 1'b1;
            mem_wa = e_base + AW'(e_ptr);
            mem_wd = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (mem_we && rp_n) begin
            mem[mem_wa] <= mem_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rp_n) begin
            e_act <= 1'b0; e_susp <= 1'b0; w_act <= 1'b0; w_susp <= 1'b0;
            e_cnt <= '0; w_cnt <= '0; e_ptr <= '0; e_last <= '0;
            e_base <= '0; w_addr <= '0; w_data <= '0;
            f_er <= 1'b0; f_wr <= 1'b0; f_vpp <= 1'b0; f_prot <= 1'b0;
        end else begin
            if (w_run) begin
                if (w_cnt != '0) w_cnt <= w_cnt - 1'b1;
                else             w_act <= 1'b0;
            end
            if (e_run) begin
                if (e_cnt != '0)          e_cnt <= e_cnt - 1'b1;
                else if (e_ptr == e_last) e_act <= 1'b0;
                else                      e_ptr <= e_ptr + 1'b1;
            end
            case (req.kind)
                RQ_ERASE: if (idle) begin
                    if (vpp_low)       f_vpp  <= 1'b1;
                    else if (prot_hit) f_prot <= 1'b1;
                    else begin
                        e_act  <= 1'b1;
                        e_cnt  <= CW'(BUSY_CYC);
                        e_ptr  <= '0;
                        e_base <= blk_base(req.addr, boot_top);
                        e_last <= is_main(req.addr, boot_top) ? '1 : PW'((1 << SUB_W) - 1);
                    end
                end
                RQ_ERASE_BAD: begin
                    f_er <= 1'b1;
                    f_wr <= 1'b1;
                end
                RQ_WRITE: if (!w_act && (!e_act || e_susp)) begin
                    if (vpp_low)       f_vpp  <= 1'b1;
                    else if (prot_hit) f_prot <= 1'b1;
                    else if (e_act && blk_base(req.addr, boot_top) == e_base) f_wr <= 1'b1;
                    else begin
                        w_act  <= 1'b1;
                        w_cnt  <= CW'(BUSY_CYC);
                        w_addr <= req.addr;
                        w_data <= req.data;
                    end
                end
                RQ_SUSPEND: begin
                    if (w_run)                w_susp <= 1'b1;
                    else if (e_act && !e_susp) e_susp <= 1'b1;
                end
                RQ_RESUME: begin
                    if (w_susp)               w_susp <= 1'b0;
                    else if (e_susp && !w_act) e_susp <= 1'b0;
                end
                RQ_CLEAR: begin
                    f_er <= 1'b0; f_wr <= 1'b0; f_vpp <= 1'b0; f_prot <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_erase_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(e_act) |-> $past(req.kind == RQ_ERASE));
    assert_suspend_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(w_susp) |-> $past(req.kind == RQ_SUSPEND));
    assert_resume_cause_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(e_susp) && e_act) |-> $past(req.kind == RQ_RESUME));
    assert_boot_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (req.kind == RQ_WRITE && prot_hit && !vpp_low && idle && rp_n)
        |=> (!w_act && sr[1]));
    assert_vpp_lock_R10: assert property (@(posedge clk) disable iff (rst)
        ((req.kind == RQ_WRITE || req.kind == RQ_ERASE) && vpp_low && idle && rp_n)
        |=> (idle && sr[3]));
endmodule

// File: rtl/fci_readout.sv
module fci_readout
    import fci_pkg::*;
#(
    parameter logic [DW-1:0] MFG_ID = 16'h0042,
    parameter logic [DW-1:0] DEV_ID = 16'h00A7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rp_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  rmode_e        mode,
    input  logic [7:0]    sr,
    input  logic [DW-1:0] arr_word,
    input  logic          id_sel,
    output logic [DW-1:0] rdata
);
    logic       en, en_q;
    logic [7:0] snap, shown;

    assign en    = !ce_n && !oe_n;
    assign shown = (en && !en_q) ? sr : snap;

    always_ff @(posedge clk) begin
        if (rst || !rp_n) begin
            en_q <= 1'b0;
            snap <= 8'h80;
        end else begin
            en_q <= en;
            if (en && !en_q) snap <= sr;
        end
    end

    always_comb begin
        rdata = '0;
        if (en) begin
            unique case (mode)
                RD_STATUS: rdata = {{(DW-8){1'b0}}, shown};
                RD_ID:     rdata = id_sel ? DEV_ID : MFG_ID;
                default:   rdata = arr_word;
            endcase
        end
    end

    assert_status_held_R8: assert property (@(posedge clk) disable iff (rst)
        (en && en_q && rp_n && mode == RD_STATUS && $past(mode) == RD_STATUS)
        |-> $stable(rdata));
endmodule

// File: rtl/fci_ctrl.sv
module fci_ctrl
    import fci_pkg::*;
#(
    parameter int             BUSY_CYC = 64,
    parameter logic [DW-1:0]  MFG_ID   = 16'h0042,
    parameter logic [DW-1:0]  DEV_ID   = 16'h00A7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rp_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          wp_n,
    input  logic          vpp_low,
    input  logic          boot_top,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ready
);
    req_t          req;
    rmode_e        mode;
    logic [7:0]    sr;
    logic [DW-1:0] arr_word;

    fci_decode u_dec (
        .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .req(req), .mode(mode)
    );

    fci_engine #(.BUSY_CYC(BUSY_CYC)) u_eng (
        .clk(clk), .rst(rst), .rp_n(rp_n), .wp_n(wp_n), .vpp_low(vpp_low),
        .boot_top(boot_top), .req(req), .rd_addr(addr), .arr_word(arr_word),
        .sr(sr), .ready(ready)
    );

    fci_readout #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_rd (
        .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n),
        .mode(mode), .sr(sr), .arr_word(arr_word), .id_sel(addr[0]),
        .rdata(rdata)
    );
endmodule

// File: tb/sim_fci_ctrl.sv
`timescale 1ns/1ps
module sim_fci_ctrl;
    logic clk = 1'b0, rst = 1'b1, rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic wp_n = 1'b1, vpp_low = 1'b0, boot_top = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ready;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    fci_ctrl #(.BUSY_CYC(24)) u0 (
        .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp_n(wp_n), .vpp_low(vpp_low), .boot_top(boot_top), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bw(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic br(input logic [8:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); d = rdata; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 2000) begin @(negedge clk); n++; end
        if (!ready) chk("watchdog ready", 16'h0, 16'h1);
    endtask

    task automatic chk_status(input string tag, input logic [7:0] exp);
        logic [15:0] d;
        bw(0, 16'h0070); br(0, d); chk(tag, d, {8'h00, exp});
    endtask

    task automatic chk_array(input string tag, input logic [8:0] a, input logic [15:0] exp);
        logic [15:0] d;
        bw(0, 16'h00FF); br(a, d); chk(tag, d, exp);
    endtask

    task automatic do_write(input logic [8:0] a, input logic [15:0] d);
        bw(a, 16'h0040); bw(a, d);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R14 ready after reset", {15'd0, ready}, 16'h1);
        br(0, d); chk("R14 array mode after reset", d, 16'hFFFF);
        chk_status("R7 idle status", 8'h80);
    endtask

    task automatic t_write();
        do_write(40, 16'h12F0); wait_ready();
        chk_status("R2 write status", 8'h80);
        chk_array("R2 write value", 40, 16'h12F0);
        bw(40, 16'h0010); bw(40, 16'hFF0F); wait_ready();
        chk_array("R2 overwrite ANDs", 40, 16'h1200);
        chk_status("R2 no error for raised bits", 8'h80);
    endtask

    task automatic t_erase();
        do_write(70, 16'h5555); wait_ready();
        do_write(63, 16'h0000); wait_ready();
        bw(33, 16'h0020); bw(33, 16'h00D0);
        chk("R1 busy during erase", {15'd0, ready}, 16'h0);
        wait_ready();
        chk_array("R1 erased word", 40, 16'hFFFF);
        chk_array("R1 erased last word", 63, 16'hFFFF);
        chk_array("R1 neighbour block kept", 70, 16'h5555);
    endtask

    task automatic t_bad_seq();
        logic [15:0] d;
        bw(33, 16'h0020); bw(33, 16'h00FF);
        br(0, d); chk("R3 bad confirm status", d, 16'h00B0);
        chk_array("R3 array unchanged", 70, 16'h5555);
        do_write(41, 16'h0001); wait_ready();
        chk_status("R11 errors persist", 8'hB0);
        bw(0, 16'h0050);
        chk_status("R11 cleared", 8'h80);
    endtask

    task automatic t_susp_write();
        logic [15:0] d;
        do_write(80, 16'h00FF);
        bw(0, 16'h00B0);
        chk_status("R4 write suspended", 8'h84);
        chk_array("R6 read during write suspend", 70, 16'h5555);
        bw(0, 16'h00D0);
        br(0, d); chk("R4 resumed busy status", d, 16'h0000);
        wait_ready();
        chk_status("R4 write done", 8'h80);
        chk_array("R4 write value after resume", 80, 16'h00FF);
    endtask

    task automatic t_susp_erase();
        do_write(100, 16'h0000); wait_ready();
        bw(100, 16'h0020); bw(100, 16'h00D0); bw(0, 16'h00B0);
        chk_status("R4 erase suspended", 8'hC0);
        chk_array("R6 read during erase suspend", 100, 16'h0000);
        do_write(10, 16'hABCD);
        chk("R5 nested write busy", {15'd0, ready}, 16'h0);
        wait_ready();
        chk_status("R5 erase still suspended", 8'hC0);
        do_write(101, 16'h0000);
        chk_status("R5 same block write refused", 8'hD0);
        chk_array("R5 same block unchanged", 101, 16'hFFFF);
        bw(0, 16'h0050);
        bw(0, 16'h00D0); wait_ready();
        chk_array("R4 erase finished after resume", 100, 16'hFFFF);
        chk_array("R5 nested write value", 10, 16'hABCD);
        chk_status("R4 idle after erase", 8'h80);
    endtask

    task automatic t_latch();
        logic [15:0] d;
        int n = 0;
        do_write(200, 16'h0F0F);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); chk("R8 status captured busy", rdata, 16'h0000);
        while (!ready && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk); chk("R8 status held while enabled", rdata, 16'h0000);
        ce_n = 1'b1; oe_n = 1'b1;
        br(0, d); chk("R8 status after toggle", d, 16'h0080);
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        do_write(508, 16'h0000);
        chk_status("R9 boot lock status", 8'h82);
        chk_array("R9 boot block unchanged", 508, 16'hFFFF);
        bw(0, 16'h0050);
        do_write(480, 16'h1111); wait_ready();
        chk_status("R9 parameter block writable", 8'h80);
        wp_n = 1'b1;
        do_write(508, 16'h2222); wait_ready();
        chk_array("R9 boot writable with wp_n high", 508, 16'h2222);
    endtask

    task automatic t_vpp();
        vpp_low = 1'b1;
        bw(480, 16'h0020); bw(480, 16'h00D0);
        chk_status("R10 supply low status", 8'h88);
        chk_array("R10 array unchanged", 480, 16'h1111);
        vpp_low = 1'b0;
        bw(0, 16'h0050);
    endtask

    task automatic t_id();
        logic [15:0] d;
        bw(0, 16'h0090);
        br(0, d); chk("R12 manufacturer id", d, 16'h0042);
        br(1, d); chk("R12 device id", d, 16'h00A7);
        chk_array("R12 back to array", 480, 16'h1111);
    endtask

    task automatic t_rp();
        logic [15:0] d;
        do_write(160, 16'h0000); wait_ready();
        bw(0, 16'h0020); bw(0, 16'h0000);
        bw(160, 16'h0020); bw(160, 16'h00D0);
        @(negedge clk); rp_n = 1'b0;
        @(negedge clk); @(negedge clk); rp_n = 1'b1;
        @(negedge clk);
        chk("R14 ready after rp_n", {15'd0, ready}, 16'h1);
        br(160, d); chk("R14 array mode and data kept", d, 16'h0000);
        chk_status("R14 status cleared", 8'h80);
    endtask

    task automatic t_strap();
        @(negedge clk); rst = 1'b1; boot_top = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        wp_n = 1'b0;
        do_write(0, 16'h0000);
        chk_status("R13 bottom boot unit 0 locked", 8'h82);
        bw(0, 16'h0050);
        do_write(4, 16'h0000);
        chk_status("R13 bottom boot unit 1 locked", 8'h82);
        bw(0, 16'h0050);
        do_write(8, 16'h0000); wait_ready();
        chk_status("R13 unit 2 is parameter", 8'h80);
        chk_array("R13 unit 2 written", 8, 16'h0000);
        chk_array("R13 unit 0 kept", 0, 16'hFFFF);
        wp_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_erase();
        t_bad_seq();
        t_susp_write();
        t_susp_erase();
        t_latch();
        t_wp();
        t_vpp();
        t_id();
        t_rp();
        t_strap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule